// File: doc/BRIEF.md
# EEPROM Page-Buffer Write Model

This block is a synthesizable stand-in for the write side of a byte-wide parallel EEPROM, meant to sit on a bus as a self-checking partner for a memory controller. It samples the active-low chip enable, write enable and output enable strobes together with the address and data buses. Bytes go into a page buffer with one slot per low-order address value. The first accepted write of a sequence fixes which page of the array the whole sequence lands in.

When no further write strobe arrives within a programmable load window, the sequence closes. The model then drops its ready line for a fixed programmed write time and copies only the buffer slots that this sequence filled into the array. Strobes are ignored while ready is low. They are also ignored while the device reset pin is low and for a guard period after it is released. A simple registered read port makes the array contents visible. Every interval is a parameter counted in clock cycles, so a bench can shrink the intervals.

Top module: `eeprom_page_writer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ready` is 1 and `dout` is 0.
- R2: A sequence's page is `addr[ADDR_W-1:6]` at the first accepted falling edge of `we_n`. The page bits of later bytes in the same sequence are ignored: those bytes go to the first page, and the page they name is left untouched.
- R3: On each rising edge of `we_n` in an open byte, `din` is stored into slot `addr[5:0]` of the buffer, and it reaches that array location when the sequence is committed.
- R4: A sequence closes when `LOAD_WIN_CYC` cycles pass with `we_n` high and no new accepted falling edge. `ready` then goes to 0 no earlier than `LOAD_WIN_CYC` and no later than `LOAD_WIN_CYC+4` cycles after the last `we_n` rise. A gap shorter than the window keeps the sequence open.
- R5: `ready` stays 0 for exactly `WRITE_CYC` cycles per committed sequence, provided `WRITE_CYC` is at least 66.
- R6: Buffer slots not written in the current sequence leave their array locations unchanged.
- R7: Write strobes while `ready` is 0 are ignored. They start no new busy period and change no location.
- R8: A `we_n` fall with `oe_n` low or `ce_n` high is not accepted and starts no sequence.
- R9: While `dev_rst_n` is low, and for `max(PROT_CYC, RES_HIGH_CYC)` cycles after it goes high, write strobes are ignored. After that period, writes are accepted again.
- R10: With `ce_n`=0, `oe_n`=0 and `we_n`=1 held, `dout` shows the array byte at `addr` within three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| dev_rst_n | input | 1 | Device reset pin, active low; gates writes |
| addr | input | ADDR_W | Byte address: page in upper bits, slot in bits 5..0 |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |
| ready | output | 1 | 1 when idle, 0 during internal write |

## Verification
A full 64-byte page load checks slot placement, the latency from the last strobe to busy, and the exact busy length. A two-byte load whose second address names another page, and which covers only some slots of a filled page, separates page latching from slot merging. Two byte pairs, one spaced just under the window and one spaced beyond it, show whether the inactivity timer or the address decides where the sequence ends. Strobes sent while busy, with output enable low, with chip enable high, under device reset and in the guard period after it must all leave both `ready` and the read-back data unchanged. A final write after the guard period shows that writes are accepted again.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_BYTE = 2'd1,
    LD_GAP  = 2'd2
  } ld_state_t;

  function automatic int cyc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eepw_guard.sv
module eepw_guard #(
  parameter int PROT_CYC     = 25000,
  parameter int RES_HIGH_CYC = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic dev_rst_n_s,
  output logic prot_ok
);
  import eepw_pkg::*;

  localparam int GUARD = cyc_max(cyc_max(PROT_CYC, RES_HIGH_CYC), 1);
  localparam int CW    = $clog2(GUARD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !dev_rst_n_s) begin
      cnt_q   <= '0;
      prot_ok <= 1'b0;
    end else if (!prot_ok) begin
      if (cnt_q == CW'(GUARD - 1)) prot_ok <= 1'b1;
      else                         cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_GUARD_DROPS: assert property (@(posedge clk) disable iff (rst)
    !dev_rst_n_s |=> !prot_ok) else $error("guard open under reset"); // R9

endmodule

// File: rtl/eepw_loader.sv
module eepw_loader #(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 8,
  parameter int SLOT_W       = 6,
  parameter int LOAD_WIN_CYC = 25000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we_n_s,
  input  logic                       we_n_d,
  input  logic                       ce_n_s,
  input  logic                       oe_n_s,
  input  logic [ADDR_W-1:0]          addr_s,
  input  logic [DATA_W-1:0]          din_s,
  input  logic                       prot_ok,
  input  logic                       ready,
  input  logic [SLOT_W-1:0]          buf_rd_idx,
  output logic [DATA_W-1:0]          buf_rd_data,
  output logic                       load_done,
  output logic                       loading,
  output logic [ADDR_W-SLOT_W-1:0]   page_o,
  output logic [(1<<SLOT_W)-1:0]     valid_o
);
  import eepw_pkg::*;

  localparam int NSLOT = 1 << SLOT_W;
  localparam int PG_W  = ADDR_W - SLOT_W;
  localparam int WIN   = cyc_max(LOAD_WIN_CYC, 1);
  localparam int TW    = $clog2(WIN + 1);

  ld_state_t          st_q;
  logic [TW-1:0]      tmr_q;
  logic [PG_W-1:0]    page_q;
  logic [NSLOT-1:0]   valid_q;
  logic [DATA_W-1:0]  pbuf [NSLOT];
  logic               fall_acc;
  logic               rise;
  logic               buf_we;

  assign fall_acc = we_n_d && !we_n_s && !ce_n_s && oe_n_s && prot_ok && ready && !load_done;
  assign rise     = !we_n_d && we_n_s;
  assign buf_we   = (st_q == LD_BYTE) && rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= LD_IDLE;
      tmr_q     <= '0;
      page_q    <= '0;
      valid_q   <= '0;
      load_done <= 1'b0;
    end else begin
      load_done <= 1'b0;
      unique case (st_q)
        LD_IDLE: begin
          if (fall_acc) begin
            page_q  <= addr_s[ADDR_W-1:SLOT_W];
            valid_q <= '0;
            tmr_q   <= '0;
            st_q    <= LD_BYTE;
          end
        end
        LD_BYTE: begin
          if (rise) begin
            valid_q[addr_s[SLOT_W-1:0]] <= 1'b1;
            tmr_q <= '0;
            st_q  <= LD_GAP;
          end
        end
        LD_GAP: begin
          if (fall_acc) begin
            tmr_q <= '0;
            st_q  <= LD_BYTE;
          end else if (tmr_q == TW'(WIN - 1)) begin
            load_done <= 1'b1;
            st_q      <= LD_IDLE;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: st_q <= LD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[addr_s[SLOT_W-1:0]] <= din_s;
    buf_rd_data <= pbuf[buf_rd_idx];
  end

  assign loading = (st_q != LD_IDLE);
  assign page_o  = page_q;
  assign valid_o = valid_q;

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
    (st_q != LD_IDLE && $past(st_q) != LD_IDLE) |-> $stable(page_q)) else $error("page moved"); // R2
  AST_LOAD_HAS_BYTE: assert property (@(posedge clk) disable iff (rst)
    load_done |-> (valid_q != '0)) else $error("empty commit"); // R6

endmodule

// File: rtl/eepw_array.sv
module eepw_array #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int SLOT_W    = 6,
  parameter int WRITE_CYC = 2500000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_done,
  input  logic [ADDR_W-SLOT_W-1:0]  page_i,
  input  logic [(1<<SLOT_W)-1:0]    valid_i,
  input  logic [DATA_W-1:0]         buf_rd_data,
  output logic [SLOT_W-1:0]         buf_rd_idx,
  output logic                      ready_q,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         dout_q
);
  import eepw_pkg::*;

  localparam int NSLOT    = 1 << SLOT_W;
  localparam int PG_W     = ADDR_W - SLOT_W;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int BUSY_LEN = cyc_max(WRITE_CYC, NSLOT + 2);
  localparam int CW       = $clog2(BUSY_LEN + 1);

  logic [CW-1:0]      cnt_q;
  logic [PG_W-1:0]    page_c;
  logic               wr_en_q;
  logic [SLOT_W-1:0]  wr_slot_q;
  logic               in_walk;
  logic [DATA_W-1:0]  mem [DEPTH];

  assign buf_rd_idx = cnt_q[SLOT_W-1:0];
  assign in_walk    = !ready_q && (cnt_q < CW'(NSLOT));

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b1;
      cnt_q   <= '0;
      page_c  <= '0;
    end else if (ready_q) begin
      if (load_done) begin
        ready_q <= 1'b0;
        cnt_q   <= '0;
        page_c  <= page_i;
      end
    end else if (cnt_q == CW'(BUSY_LEN - 1)) begin
      ready_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_q   <= 1'b0;
      wr_slot_q <= '0;
    end else begin
      wr_en_q   <= in_walk && valid_i[cnt_q[SLOT_W-1:0]];
      wr_slot_q <= cnt_q[SLOT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_q) mem[{page_c, wr_slot_q}] <= buf_rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        dout_q <= '0;
    else if (rd_en) dout_q <= mem[rd_addr];
  end

  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_q) |-> $past(load_done)) else $error("busy without load"); // R4
  AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    !ready_q |-> !load_done) else $error("load closed while busy"); // R7
  AST_COMMIT_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |-> !ready_q) else $error("array write while ready"); // R5

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 8,
  parameter int LOAD_WIN_CYC = 25000,
  parameter int WRITE_CYC    = 2500000,
  parameter int PROT_CYC     = 25000,
  parameter int RES_HIGH_CYC = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              dev_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              ready
);
  localparam int SLOT_W = 6;
  localparam int PG_W   = ADDR_W - SLOT_W;
  localparam int NSLOT  = 1 << SLOT_W;

  logic              we_n_s, we_n_d, ce_n_s, oe_n_s, dev_rst_n_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              prot_ok, load_done, loading, rd_en;
  logic [PG_W-1:0]   page_w;
  logic [NSLOT-1:0]  valid_w;
  logic [SLOT_W-1:0] buf_rd_idx;
  logic [DATA_W-1:0] buf_rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_n_s      <= 1'b1;
      we_n_d      <= 1'b1;
      ce_n_s      <= 1'b1;
      oe_n_s      <= 1'b1;
      dev_rst_n_s <= 1'b0;
      addr_s      <= '0;
      din_s       <= '0;
    end else begin
      we_n_s      <= we_n;
      we_n_d      <= we_n_s;
      ce_n_s      <= ce_n;
      oe_n_s      <= oe_n;
      dev_rst_n_s <= dev_rst_n;
      addr_s      <= addr;
      din_s       <= din;
    end
  end

  assign rd_en = !ce_n_s && !oe_n_s && we_n_s;

  eepw_guard #(.PROT_CYC(PROT_CYC), .RES_HIGH_CYC(RES_HIGH_CYC)) i_guard (
    .clk(clk), .rst(rst), .dev_rst_n_s(dev_rst_n_s), .prot_ok(prot_ok)
  );

  eepw_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W),
                .LOAD_WIN_CYC(LOAD_WIN_CYC)) i_loader (
    .clk(clk), .rst(rst), .we_n_s(we_n_s), .we_n_d(we_n_d), .ce_n_s(ce_n_s),
    .oe_n_s(oe_n_s), .addr_s(addr_s), .din_s(din_s), .prot_ok(prot_ok),
    .ready(ready), .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
    .load_done(load_done), .loading(loading), .page_o(page_w), .valid_o(valid_w)
  );

  eepw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W),
               .WRITE_CYC(WRITE_CYC)) i_array (
    .clk(clk), .rst(rst), .load_done(load_done), .page_i(page_w), .valid_i(valid_w),
    .buf_rd_data(buf_rd_data), .buf_rd_idx(buf_rd_idx), .ready_q(ready),
    .rd_en(rd_en), .rd_addr(addr_s), .dout_q(dout)
  );

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!prot_ok && !loading) |=> !loading) else $error("load under guard"); // R9
  AST_STROBE_GATED: assert property (@(posedge clk) disable iff (rst)
    (!loading && (!oe_n_s || ce_n_s)) |=> !loading) else $error("gated strobe accepted"); // R8

endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
  localparam int AW = 10;
  localparam int LW = 20;
  localparam int WC = 100;
  localparam int PC = 30;
  localparam int RH = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, dev_rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       ev_rd;
  logic [7:0] model [int];

  always #2 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .DATA_W(8), .LOAD_WIN_CYC(LW), .WRITE_CYC(WC),
                       .PROT_CYC(PC), .RES_HIGH_CYC(RH)) i_eeprom_page_writer (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .dev_rst_n(dev_rst_n),
    .addr(addr), .din(din), .dout(dout), .ready(ready)
  );

  function automatic logic [AW-1:0] ad(int pg, int sl);
    return AW'(pg * 64 + sl);
  endfunction

  function automatic logic [7:0] pat(int pg, int sl);
    return 8'((pg * 37 + sl * 5 + 1) & 255);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(logic [AW-1:0] a, logic [7:0] d, logic oe_v = 1'b1, logic ce_v = 1'b0);
    addr = a; din = d; oe_n = oe_v; ce_n = ce_v;
    tick(1); we_n = 1'b0;
    tick(2); we_n = 1'b1;
    tick(1); ce_n = 1'b1; oe_n = 1'b1;
    tick(1);
  endtask

  // driver side of the scoreboard: push expectation, then trigger the monitor
  task automatic rd(logic [AW-1:0] a, string tag);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    tick(3);
    exp_q.push_back(model.exists(int'(a)) ? model[int'(a)] : 8'h00);
    tag_q.push_back(tag);
    -> ev_rd;
    tick(1);
    ce_n = 1'b1; oe_n = 1'b1;
    tick(1);
  endtask

  initial begin : monitor
    forever begin
      @(ev_rd);
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(dout === e, t, int'(dout), int'(e));
      end
    end
  end

  task automatic busy_cycle(output int lat, output int len);
    lat = 0; len = 0;
    while (ready === 1'b1 && lat < 1000) begin tick(1); lat++; end
    while (ready === 1'b0 && len < 10000) begin len++; tick(1); end
  endtask

  task automatic no_busy(int n, string tag);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (ready !== 1'b1) lows++;
    end
    chk(lows == 0, tag, lows, 0);
  endtask

  task automatic fill_page(int pg);
    int lat, len;
    for (int s = 0; s < 64; s++) begin
      wr_byte(ad(pg, s), pat(pg, s));
      model[int'(ad(pg, s))] = pat(pg, s);
    end
    busy_cycle(lat, len);
    chk(lat >= LW - 1 && lat <= LW + 3, "R4 busy latency", lat, LW + 1);
    chk(len == WC, "R5 busy length", len, WC);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int lat, len;
    tick(4);
    chk(ready === 1'b1, "R1 ready in reset", int'(ready), 1);
    chk(dout === 8'h00, "R1 dout in reset", int'(dout), 0);
    rst = 1'b0;
    tick(1);
    chk(ready === 1'b1, "R1 ready after reset", int'(ready), 1);
    chk(dout === 8'h00, "R1 dout after reset", int'(dout), 0);

    // R9: strobe under device reset, then right after release
    wr_byte(ad(1, 0), 8'hEE);
    no_busy(LW + 10, "R9 write under dev reset");
    dev_rst_n = 1'b1;
    tick(1);
    wr_byte(ad(1, 0), 8'hED);
    no_busy(LW + 10, "R9 write in guard period");
    tick(PC + RH);

    // R3/R4/R5/R10: full page loads
    fill_page(3);
    fill_page(7);
    rd(ad(3, 0),  "R3 slot 0");
    rd(ad(3, 31), "R3 slot 31");
    rd(ad(3, 63), "R10 read slot 63");
    rd(ad(7, 9),  "R10 read page 7");

    // R2/R6: partial load, second byte names another page
    wr_byte(ad(3, 5), 8'hA5);
    wr_byte(ad(7, 9), 8'hC9);
    model[int'(ad(3, 5))] = 8'hA5;
    model[int'(ad(3, 9))] = 8'hC9;
    // R7: strobe during the busy period
    while (ready === 1'b1) tick(1);
    tick(5);
    wr_byte(ad(7, 1), 8'h5A);
    while (ready === 1'b0) tick(1);
    no_busy(LW + 10, "R7 no busy after busy-time strobe");
    rd(ad(3, 5), "R3 partial slot 5");
    rd(ad(3, 9), "R2 byte placed in first page");
    rd(ad(7, 9), "R2 named page untouched");
    rd(ad(3, 6), "R6 unloaded slot kept");
    rd(ad(7, 1), "R7 busy strobe ignored");

    // R8: oe low, ce high
    wr_byte(ad(3, 0), 8'h11, 1'b0, 1'b0);
    no_busy(LW + 10, "R8 oe low no busy");
    wr_byte(ad(3, 0), 8'h12, 1'b1, 1'b1);
    no_busy(LW + 10, "R8 ce high no busy");
    rd(ad(3, 0), "R8 data kept");

    // R4: gap just under the window keeps one sequence
    wr_byte(ad(2, 4), 8'h44);
    tick(LW - 8);
    wr_byte(ad(5, 6), 8'h66);
    model[int'(ad(2, 4))] = 8'h44;
    model[int'(ad(2, 6))] = 8'h66;
    busy_cycle(lat, len);
    chk(len == WC, "R5 busy length short load", len, WC);
    rd(ad(2, 6), "R4 short gap same page");
    // R4: gap beyond the window splits the sequence
    wr_byte(ad(2, 4), 8'h77);
    busy_cycle(lat, len);
    wr_byte(ad(5, 6), 8'h88);
    busy_cycle(lat, len);
    model[int'(ad(2, 4))] = 8'h77;
    model[int'(ad(5, 6))] = 8'h88;
    rd(ad(5, 6), "R4 long gap new page");
    rd(ad(2, 6), "R4 long gap old page kept");
    rd(ad(2, 4), "R4 first load committed");

    // R9: reset pulse mid-run, then accepted write after guard
    dev_rst_n = 1'b0;
    tick(3);
    wr_byte(ad(3, 0), 8'h99);
    dev_rst_n = 1'b1;
    tick(2);
    wr_byte(ad(3, 0), 8'h98);
    no_busy(LW + 10, "R9 guard blocks busy");
    rd(ad(3, 0), "R9 data kept under guard");
    tick(PC + RH);
    wr_byte(ad(3, 0), 8'h97);
    busy_cycle(lat, len);
    chk(len == WC, "R9 write accepted after guard", len, WC);
    model[int'(ad(3, 0))] = 8'h97;
    rd(ad(3, 0), "R9 data after guard");

    tick(2);
    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule